// File: doc/BRIEF.md
# Runahead Execution Mode Controller

This block models the speculative pre-execution mode of a small in-order pipeline. Instructions arrive one at a time on a valid/ready stream. Each instruction carries its program counter, its operation, its register numbers, an immediate, and for loads the cache outcome: either a hit with its data, or a last-level miss. In normal mode instructions execute and retire. Retiring means a register writeback or a memory store on the output ports.

When a load misses in the last-level cache in normal mode, the controller does not stall. It copies the register file into a checkpoint and switches to runahead mode. It then keeps executing the instructions that follow. Each register carries an invalid flag: results that depend on the missing data are flagged and never used to form an address. Every load whose address register is valid issues one prefetch. Nothing computed in runahead mode retires.

When the miss-return pulse arrives, the checkpoint is copied back and all invalid flags are cleared. A redirect carrying the missing load's program counter then asks the front end to fetch again from that load.

Top module: `runahead_ctrl`

## Requirements
- R1: Runahead mode is entered only when a load (op code 2) with its miss flag set is accepted in normal mode. A load that hits never changes the mode, and a miss accepted during runahead mode neither re-enters the mode nor takes a new checkpoint.
- R2: On entry, the register file is saved as it stood before the missing load. The missing load does not retire, and its destination register is flagged invalid.
- R3: In runahead mode, an ALU instruction (op code 1, result rs1 + rs2 + imm) flags its destination invalid when either source is invalid. It clears the flag when both sources are valid.
- R4: In runahead mode, a load whose address register (rs1) is invalid issues no prefetch and flags its destination invalid. A load with a valid address that misses also flags its destination invalid.
- R5: In runahead mode, a load with a valid address register issues exactly one prefetch, with address rs1 + imm, on the cycle after it is accepted.
- R6: In runahead mode, no instruction produces a register writeback, and no store (op code 3) produces a memory write.
- R7: A miss return in runahead mode restores every register from the checkpoint and returns to normal mode. On the next cycle it pulses a redirect carrying the missing load's program counter. A miss return in normal mode has no effect.
- R8: When a miss return and an instruction are offered in the same runahead cycle, in_ready is low. The return is taken and that instruction is not accepted, so it causes no prefetch.
- R9: ra_active shows the current mode. pf_count is cleared on entry, counts the prefetches issued in the current runahead episode, and holds that count after exit.
- R10: In normal mode, one cycle after acceptance: an ALU instruction writes rs1 + rs2 + imm to rd; a hitting load writes its data to rd; a store writes rs2 to address rs1 + imm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_pc | input | PCW | Program counter of the instruction |
| in_op | input | 2 | 0 none, 1 ALU add, 2 load, 3 store |
| in_rd | input | IDXW | Destination register |
| in_rs1 | input | IDXW | First source / address base register |
| in_rs2 | input | IDXW | Second source / store data register |
| in_imm | input | XLEN | Immediate |
| in_miss | input | 1 | Load misses in the last-level cache |
| in_ldata | input | XLEN | Load data when the load hits |
| ret_valid | input | 1 | Data of the outstanding miss has returned |
| wb_valid | output | 1 | Architectural register writeback |
| wb_reg | output | IDXW | Writeback register |
| wb_data | output | XLEN | Writeback value |
| st_valid | output | 1 | Architectural memory store |
| st_addr | output | XLEN | Store address |
| st_data | output | XLEN | Store data |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | XLEN | Prefetch address |
| redirect_valid | output | 1 | Restart fetch at redirect_pc |
| redirect_pc | output | PCW | Program counter of the missing load |
| ra_active | output | 1 | Runahead mode is active |
| pf_count | output | CNTW | Prefetches in the current or last episode |

## Verification
The two events that can fall in the same cycle are the miss return and the arrival of a new runahead instruction. The bench provokes this by raising ret_valid together with a load whose address register is valid, in the same cycle. It first reads in_ready low while both are offered. After the edge it expects: no prefetch, an unchanged episode count, the mode back to normal, and a redirect to the missing load. Instructions issued after that show that the checkpointed register values, and not the runahead results, are the ones left.

// File: rtl/rh_pkg.sv
// Shared encodings for the runahead controller.
// Assumes: two-bit operation field; mode is a two-state machine.
package rh_pkg;
    localparam logic [1:0] OP_NOP = 2'd0;
    localparam logic [1:0] OP_ALU = 2'd1;
    localparam logic [1:0] OP_LD  = 2'd2;
    localparam logic [1:0] OP_ST  = 2'd3;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_AHEAD  = 1'b1
    } mode_e;
endpackage

// File: rtl/rh_regfile.sv
// Working register file with a per-register invalid flag and a full
// checkpoint copy. Restore beats snapshot, which beats a normal write.
// Assumes: snapshot and restore never coincide with a write.
module rh_regfile #(
    parameter int NREG = 8,
    parameter int XLEN = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [IDXW-1:0] rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    output logic            ra_bad,
    output logic            rb_bad,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic            wr_bad,
    input  logic            snap,
    input  logic [IDXW-1:0] snap_bad_idx,
    input  logic            restore
);
    logic [XLEN-1:0] val_vec [NREG];
    logic [NREG-1:0] bad_vec;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [XLEN-1:0] val_q;
        logic [XLEN-1:0] cp_q;
        logic            bad_q;

        // Per-register update: restore, checkpoint, or ordinary write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                cp_q  <= '0;
                bad_q <= 1'b0;
            end else if (restore) begin
                val_q <= cp_q;
                bad_q <= 1'b0;
            end else if (snap) begin
                cp_q  <= val_q;
                bad_q <= (int'(snap_bad_idx) == i);
            end else if (wr_en && (int'(wr_idx) == i)) begin
                val_q <= wr_val;
                bad_q <= wr_bad;
            end
        end

        assign val_vec[i] = val_q;
        assign bad_vec[i] = bad_q;
    end

    // Read ports.
    always_comb begin
        ra_val = val_vec[ra_idx];
        rb_val = val_vec[rb_idx];
        ra_bad = bad_vec[ra_idx];
        rb_bad = bad_vec[rb_idx];
    end

    // R7: one cycle after a restore no register may be flagged invalid.
    p_restore_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (bad_vec == '0));
endmodule

// File: rtl/rh_exec.sv
// Combinational execute stage. It decides the register write, the
// invalid flag, the prefetch, the store and the miss trigger for one
// instruction in the current mode.
// Assumes: operands and flags come from rh_regfile in the same cycle.
module rh_exec #(
    parameter int XLEN = 16
) (
    input  logic [1:0]      op,
    input  logic            ahead,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    input  logic            a_bad,
    input  logic            b_bad,
    input  logic [XLEN-1:0] imm,
    input  logic            miss,
    input  logic [XLEN-1:0] ldata,
    output logic            wr_en,
    output logic [XLEN-1:0] wr_val,
    output logic            wr_bad,
    output logic            pf_req,
    output logic            st_req,
    output logic [XLEN-1:0] addr,
    output logic            miss_trig
);
    import rh_pkg::*;

    assign addr = a_val + imm;

    // Per-operation decode of results, invalid flags and side effects.
    always_comb begin
        wr_en     = 1'b0;
        wr_val    = '0;
        wr_bad    = 1'b0;
        pf_req    = 1'b0;
        st_req    = 1'b0;
        miss_trig = 1'b0;
        unique case (op)
            OP_ALU: begin
                wr_en  = 1'b1;
                wr_val = a_val + b_val + imm;
                wr_bad = ahead && (a_bad || b_bad);
            end
            OP_LD: begin
                if (!ahead) begin
                    if (miss) begin
                        miss_trig = 1'b1;
                    end else begin
                        wr_en  = 1'b1;
                        wr_val = ldata;
                    end
                end else if (a_bad) begin
                    wr_en  = 1'b1;
                    wr_bad = 1'b1;
                end else begin
                    pf_req = 1'b1;
                    wr_en  = 1'b1;
                    wr_val = ldata;
                    wr_bad = miss;
                end
            end
            OP_ST: st_req = !ahead;
            default: ;
        endcase
    end
endmodule

// File: rtl/rh_mode_fsm.sv
// Mode state machine: enters runahead on a normal-mode miss, leaves on
// the miss return, remembers the missing load's PC and emits the redirect.
// Assumes: accept is in_valid qualified by this block's in_ready.
module rh_mode_fsm #(
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           miss_trig,
    input  logic [PCW-1:0] pc,
    input  logic           ret_valid,
    output logic           ahead,
    output logic           snap,
    output logic           restore,
    output logic           ready,
    output logic           redirect_valid,
    output logic [PCW-1:0] redirect_pc
);
    import rh_pkg::*;

    mode_e          mode_q;
    logic [PCW-1:0] miss_pc_q;

    assign ahead   = (mode_q == MODE_AHEAD);
    assign restore = ahead && ret_valid;
    assign ready   = !restore;
    assign snap    = accept && miss_trig && !ahead;

    // Mode register and recorded miss PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_NORMAL;
            miss_pc_q <= '0;
        end else if (restore) begin
            mode_q <= MODE_NORMAL;
        end else if (snap) begin
            mode_q    <= MODE_AHEAD;
            miss_pc_q <= pc;
        end
    end

    // Redirect pulse follows the restore by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= restore;
            if (restore) redirect_pc <= miss_pc_q;
        end
    end

    // R1: entry only follows an accepted normal-mode miss.
    p_entry_on_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ahead) |-> $past(accept && miss_trig));
    // R7: leaving runahead mode always comes with a redirect.
    p_exit_redirects_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ahead) |-> redirect_valid);
    // R8: nothing is accepted while a return is being taken.
    p_return_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead && ret_valid && accept) |-> 1'b0);
endmodule

// File: rtl/rh_prefetch.sv
// Prefetch request register and per-episode prefetch counter.
// Assumes: fire is only raised for accepted runahead loads with a
// valid address; clear is the entry pulse.
module rh_prefetch #(
    parameter int XLEN = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ahead,
    input  logic            fire,
    input  logic [XLEN-1:0] addr,
    input  logic            clear,
    output logic            pf_valid,
    output logic [XLEN-1:0] pf_addr,
    output logic [CNTW-1:0] pf_count
);
    localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

    // Request register: one cycle pulse per fired load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) pf_addr <= addr;
        end
    end

    // Saturating episode counter, cleared on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_count <= '0;
        end else if (clear) begin
            pf_count <= '0;
        end else if (fire && pf_count != CMAX) begin
            pf_count <= pf_count + 1'b1;
        end
    end

    // R5: prefetches only come from runahead mode.
    p_pf_in_ahead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ahead));
    // R9: the counter moves only with a prefetch or an entry.
    p_count_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pf_count) |-> (pf_valid || $past(clear)));
endmodule

// File: rtl/runahead_ctrl.sv
// Top of the runahead controller: connects the register file, execute
// stage, mode machine and prefetch unit, and registers the
// architectural writeback and store ports.
// Assumes: the front end replays from redirect_pc after a redirect.
module runahead_ctrl #(
    parameter int NREG = 8,
    parameter int XLEN = 16,
    parameter int PCW  = 16,
    parameter int CNTW = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PCW-1:0]  in_pc,
    input  logic [1:0]      in_op,
    input  logic [IDXW-1:0] in_rd,
    input  logic [IDXW-1:0] in_rs1,
    input  logic [IDXW-1:0] in_rs2,
    input  logic [XLEN-1:0] in_imm,
    input  logic            in_miss,
    input  logic [XLEN-1:0] in_ldata,
    input  logic            ret_valid,
    output logic            wb_valid,
    output logic [IDXW-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            pf_valid,
    output logic [XLEN-1:0] pf_addr,
    output logic            redirect_valid,
    output logic [PCW-1:0]  redirect_pc,
    output logic            ra_active,
    output logic [CNTW-1:0] pf_count
);
    logic            ahead, snap, restore, ready, accept;
    logic [XLEN-1:0] a_val, b_val, wr_val, addr;
    logic            a_bad, b_bad, wr_en, wr_bad, pf_req, st_req, miss_trig;

    assign in_ready  = ready;
    assign accept    = in_valid && ready;
    assign ra_active = ahead;

    rh_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(in_rs1), .rb_idx(in_rs2),
        .ra_val(a_val), .rb_val(b_val), .ra_bad(a_bad), .rb_bad(b_bad),
        .wr_en(accept && wr_en), .wr_idx(in_rd), .wr_val(wr_val), .wr_bad(wr_bad),
        .snap(snap), .snap_bad_idx(in_rd), .restore(restore)
    );

    rh_exec #(.XLEN(XLEN)) u_ex (
        .op(in_op), .ahead(ahead),
        .a_val(a_val), .b_val(b_val), .a_bad(a_bad), .b_bad(b_bad),
        .imm(in_imm), .miss(in_miss), .ldata(in_ldata),
        .wr_en(wr_en), .wr_val(wr_val), .wr_bad(wr_bad),
        .pf_req(pf_req), .st_req(st_req), .addr(addr), .miss_trig(miss_trig)
    );

    rh_mode_fsm #(.PCW(PCW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .miss_trig(miss_trig), .pc(in_pc), .ret_valid(ret_valid),
        .ahead(ahead), .snap(snap), .restore(restore), .ready(ready),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    rh_prefetch #(.XLEN(XLEN), .CNTW(CNTW)) u_pf (
        .clk(clk), .rst_n(rst_n), .ahead(ahead),
        .fire(accept && pf_req), .addr(addr), .clear(snap),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_count(pf_count)
    );

    // Architectural retire: writeback and store, normal mode only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_reg   <= '0;
            wb_data  <= '0;
            st_valid <= 1'b0;
            st_addr  <= '0;
            st_data  <= '0;
        end else begin
            wb_valid <= accept && wr_en && !ahead;
            st_valid <= accept && st_req;
            if (accept && wr_en && !ahead) begin
                wb_reg  <= in_rd;
                wb_data <= wr_val;
            end
            if (accept && st_req) begin
                st_addr <= addr;
                st_data <= b_val;
            end
        end
    end

    // R6: no writeback leaves the block for a runahead instruction.
    p_wb_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !$past(ahead));
    // R6: no store leaves the block for a runahead instruction.
    p_st_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !$past(ahead));
endmodule

// File: tb/sim_runahead_ctrl.sv
module sim_runahead_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_pc = '0;
    logic [1:0]  in_op = '0;
    logic [2:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [15:0] in_imm = '0, in_ldata = '0;
    logic        in_miss = 1'b0, ret_valid = 1'b0;
    logic        wb_valid, st_valid, pf_valid, redirect_valid, ra_active;
    logic [2:0]  wb_reg;
    logic [15:0] wb_data, st_addr, st_data, pf_addr, redirect_pc;
    logic [7:0]  pf_count;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    runahead_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one instruction for one cycle; returns at the negedge after the accepting edge.
    task automatic send(input logic [1:0] op, input int rd, input int rs1, input int rs2,
                        input logic [15:0] imm, input logic miss, input logic [15:0] ld,
                        input logic [15:0] pc);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_rd = 3'(rd); in_rs1 = 3'(rs1); in_rs2 = 3'(rs2);
        in_imm = imm; in_miss = miss; in_ldata = ld; in_pc = pc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 reset mode", ra_active, 0);
        chk("R9 reset count", pf_count, 0);
        chk("R10 reset wb", wb_valid, 0);
        chk("R5 reset pf", pf_valid, 0);
        chk("R8 reset ready", in_ready, 1);
    endtask

    task automatic t_normal;
        send(2'd1, 1, 0, 0, 16'd5, 0, 0, 16'h10);
        chk("R10 alu wb", {wb_valid, 13'd0, wb_reg, wb_data}, {1'b1, 13'd0, 3'd1, 16'd5});
        send(2'd1, 2, 1, 1, 16'd1, 0, 0, 16'h11);
        chk("R10 alu two src", wb_data, 16'd11);
        send(2'd2, 3, 1, 0, 16'd0, 0, 16'h77, 16'h12);
        chk("R10 load hit", {wb_valid, wb_data}, {1'b1, 16'h77});
        chk("R1 hit keeps mode", ra_active, 0);
        send(2'd3, 0, 1, 2, 16'h20, 0, 0, 16'h13);
        chk("R10 store", {st_valid, st_addr, st_data}, {1'b1, 16'h25, 16'd11});
    endtask

    task automatic t_ret_ignored;
        @(negedge clk); ret_valid = 1'b1;
        @(negedge clk); ret_valid = 1'b0;
        chk("R7 return in normal mode", {ra_active, redirect_valid}, 0);
    endtask

    task automatic t_enter;
        send(2'd2, 4, 1, 0, 16'h100, 1, 0, 16'h40);
        chk("R1 enter on miss", ra_active, 1);
        chk("R2 miss load no wb", wb_valid, 0);
        chk("R9 count cleared", pf_count, 0);
    endtask

    task automatic t_runahead;
        send(2'd1, 5, 4, 1, 16'd0, 0, 0, 16'h41);
        chk("R6 no wb in runahead", wb_valid, 0);
        send(2'd2, 3, 5, 0, 16'd0, 0, 16'h11, 16'h42);
        chk("R3 inv via alu blocks pf", pf_valid, 0);
        send(2'd1, 6, 1, 0, 16'd2, 0, 0, 16'h43);
        send(2'd2, 7, 6, 0, 16'd3, 0, 16'h55, 16'h44);
        chk("R5 prefetch addr", {pf_valid, pf_addr}, {1'b1, 16'd10});
        chk("R9 count 1", pf_count, 1);
        send(2'd2, 2, 1, 0, 16'h8, 1, 0, 16'h45);
        chk("R4 missing load still prefetches", {pf_valid, pf_addr}, {1'b1, 16'hd});
        chk("R1 no re-entry", pf_count, 2);
        send(2'd2, 3, 2, 0, 16'd0, 0, 16'h22, 16'h46);
        chk("R4 inv addr no pf", {pf_valid, pf_count}, {1'b0, 8'd2});
        send(2'd1, 2, 1, 0, 16'd0, 0, 0, 16'h47);
        send(2'd2, 7, 2, 0, 16'd0, 0, 16'h33, 16'h48);
        chk("R3 valid result clears inv", {pf_valid, pf_addr}, {1'b1, 16'd5});
        send(2'd3, 0, 1, 2, 16'h0, 0, 0, 16'h49);
        chk("R6 no store in runahead", st_valid, 0);
        chk("R9 mode active", ra_active, 1);
    endtask

    task automatic t_collision;
        @(negedge clk);
        ret_valid = 1'b1; in_valid = 1'b1; in_op = 2'd2; in_rd = 3'd7; in_rs1 = 3'd1;
        in_imm = 16'h30; in_miss = 1'b0; in_pc = 16'h4a;
        #1 chk("R8 ready low on collision", in_ready, 0);
        @(negedge clk);
        ret_valid = 1'b0; in_valid = 1'b0;
        chk("R8 colliding load not taken", pf_valid, 0);
        chk("R9 count held", pf_count, 3);
        chk("R7 back to normal", ra_active, 0);
        chk("R7 redirect", {redirect_valid, redirect_pc}, {1'b1, 16'h40});
    endtask

    task automatic t_restore;
        send(2'd1, 7, 2, 6, 16'd0, 0, 0, 16'h40);
        chk("R2 checkpoint values restored", wb_data, 16'd11);
        send(2'd1, 5, 3, 0, 16'd0, 0, 0, 16'h41);
        chk("R7 r3 restored", wb_data, 16'h77);
        send(2'd2, 4, 1, 0, 16'h100, 0, 16'h99, 16'h40);
        chk("R10 replayed load", {wb_valid, wb_reg, wb_data}, {1'b1, 3'd4, 16'h99});
        send(2'd1, 5, 4, 0, 16'd0, 0, 0, 16'h41);
        chk("R7 inv cleared", {wb_valid, wb_data}, {1'b1, 16'h99});
        chk("R9 count held in normal", pf_count, 3);
    endtask

    task automatic t_second;
        send(2'd2, 1, 0, 0, 16'h0, 1, 0, 16'h80);
        chk("R9 second entry clears count", {ra_active, pf_count}, {1'b1, 8'd0});
        @(negedge clk); ret_valid = 1'b1;
        @(negedge clk); ret_valid = 1'b0;
        chk("R7 second redirect", {redirect_valid, redirect_pc}, {1'b1, 16'h80});
        send(2'd1, 7, 1, 0, 16'd0, 0, 0, 16'h80);
        chk("R2 second checkpoint", wb_data, 16'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_ret_ignored();
        t_enter();
        t_runahead();
        t_collision();
        t_restore();
        t_second();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule